// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an 8-bit processor to memory outside the chip over a multiplexed bus. The low address byte and the data share one 8-bit line group. The high address byte has its own pins. An address-latch strobe (ALE, active high) and active-low write and read strobes complete the bus. Every bus event is timed from the internal clock. The block assumes no phase relation to any clock outside the chip.

A 9-bit control register configures the block. It holds an enable bit, a 3-bit split code that divides the external space into a lower and an upper sector, a 2-bit wait-state field for each sector, and a bus-keeper bit. While the enable bit is 0, the pins are given back to the general-purpose port settings.

The CPU side is a single request channel with valid/ready. The CPU raises `req_valid` with the address, direction and write data, and must hold all of them stable until it sees `req_ready`. `req_ready` is the back-pressure. It stays low for the whole external access and is high for exactly one cycle, when the access is complete. For reads, `rsp_rdata` is valid in that same cycle. The transfer happens on the clock edge where valid and ready are both high. A request made while the interface is disabled is never accepted.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the control register is all zero, so the interface is disabled, the keeper is off and the split code is 000. `req_ready` is 0.
- R2: While the enable bit (control bit 0) is 1, the controller owns the pins whatever the port direction settings are. The high-address and strobe output enables are all 1. When idle, `pad_ctl_o` is 3'b110, where bit 0 is ALE, bit 1 is the write strobe (active low) and bit 2 is the read strobe (active low). The shared bus is not driven when idle.
- R3: While the enable bit is 0, every pin output and output enable equals the matching `gpio_*_out` and `gpio_*_dir` input.
- R4: Each access starts with exactly one cycle of ALE high, with the full address driven. This is followed by one cycle with ALE low and the low address still driven. Then exactly one strobe is asserted. The two strobes are never active together.
- R5: The strobe stays asserted for 1 + W cycles, where W is the selected 2-bit wait-state code (0 to 3).
- R6: With split code 000, W for every address comes from the upper-sector field (control bits 7:6).
- R7: With split code k (1 to 7, control bits 3:1), an address below k*0x2000 uses the lower-sector field (control bits 5:4). Any other address uses the upper-sector field.
- R8: During the read strobe the shared bus is released. The value on `pad_ad_i` in the last strobe cycle is returned on `rsp_rdata` together with `req_ready`.
- R9: During the write strobe, and in the cycle after it, the shared bus drives the write data.
- R10: `req_ready` rises in the (4+W)-th cycle after the request is first seen, and lasts one cycle. While the interface is disabled, no request is accepted and no strobe toggles.
- R11: With the keeper bit (control bit 8) at 1, every shared-bus line the block does not drive is held at the last value seen on it, through `pad_ad_hold_en` and `pad_ad_hold_val`. With the keeper bit at 0, `pad_ad_hold_en` is 0.
- R12: The keeper works according to its own bit, whatever the enable bit is.
- R13: The high address byte stays constant from the ALE cycle until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Control value: [0] enable, [3:1] split code, [5:4] lower wait states, [7:6] upper wait states, [8] keeper |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Access complete; transfer on this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | External address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid with `req_ready` |
| gpio_ad_out | input | 8 | Port output value for the shared pins |
| gpio_ad_dir | input | 8 | Port direction for the shared pins (1 = output) |
| gpio_hi_out | input | 8 | Port output value for the high-address pins |
| gpio_hi_dir | input | 8 | Port direction for the high-address pins |
| gpio_ctl_out | input | 3 | Port output value for the strobe pins |
| gpio_ctl_dir | input | 3 | Port direction for the strobe pins |
| pad_ad_i | input | 8 | Value seen on the shared bus |
| pad_ad_o | output | 8 | Value driven on the shared bus |
| pad_ad_oe | output | 8 | Shared bus output enable per line |
| pad_ad_hold_en | output | 8 | Keeper active per line |
| pad_ad_hold_val | output | 8 | Value the keeper holds per line |
| pad_hi_o | output | 8 | High address byte pins |
| pad_hi_oe | output | 8 | High address output enable |
| pad_ctl_o | output | 3 | {read strobe n, write strobe n, ALE} |
| pad_ctl_oe | output | 3 | Strobe pin output enables |

## Verification
The assertions assume the CPU keeps `req_valid` and the request fields stable from the first cycle of a request until the handshake. They also assume the control register is not rewritten while an access is in flight. Either event would change wait states or pin ownership in the middle of a strobe. The stimulus keeps within these rules: it writes the control register only when the controller is idle, and it drops `req_valid` only after the cycle in which it saw `req_ready`. The external memory model drives the bus only while the read strobe is low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_LIM_W = 3;
  localparam int XB_WS_W  = 2;
  localparam int XB_CFG_W = 1 + XB_LIM_W + 2 * XB_WS_W + 1;

  typedef struct packed {
    logic                keep;
    logic [XB_WS_W-1:0]  ws_up;
    logic [XB_WS_W-1:0]  ws_lo;
    logic [XB_LIM_W-1:0] lim;
    logic                en;
  } xb_cfg_t;

  typedef enum logic [2:0] {
    XB_IDLE = 3'd0,
    XB_ALE  = 3'd1,
    XB_HOLD = 3'd2,
    XB_STRB = 3'd3,
    XB_DONE = 3'd4
  } xb_state_e;
endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
  import xbus_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [XB_CFG_W-1:0] wdata,
  output xb_cfg_t             cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (we) cfg <= xb_cfg_t'(wdata);
  end
endmodule

// File: rtl/xbus_sector_sel.sv
module xbus_sector_sel
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int STEP_LOG2 = 13
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [XB_LIM_W-1:0] lim,
  input  logic [XB_WS_W-1:0]  ws_lo,
  input  logic [XB_WS_W-1:0]  ws_up,
  output logic [XB_WS_W-1:0]  ws
);
  localparam int N_LIM = 1 << XB_LIM_W;
  localparam int BW    = ADDR_W + 1;

  logic [BW-1:0] bound [N_LIM];

  for (genvar k = 0; k < N_LIM; k++) begin : g_bound
    assign bound[k] = BW'(k) << STEP_LOG2;
  end

  logic below;
  assign below = ({1'b0, addr} < bound[lim]);

  always_comb begin
    if (lim == '0)  ws = ws_up;
    else if (below) ws = ws_lo;
    else            ws = ws_up;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [XB_WS_W-1:0] ws_sel,
  input  logic [DATA_W-1:0]  bus_in,
  output logic               req_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               ale,
  output logic               wr_n,
  output logic               rd_n,
  output logic               ad_drive,
  output logic [DATA_W-1:0]  ad_val,
  output logic [HI_W-1:0]    hi_val
);
  xb_state_e          st;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               we_q;
  logic [XB_WS_W-1:0] ws_q;
  logic [XB_WS_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= XB_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      ws_q    <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        XB_IDLE: if (en && req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          we_q    <= req_write;
          ws_q    <= ws_sel;
          st      <= XB_ALE;
        end
        XB_ALE:  st <= XB_HOLD;
        XB_HOLD: begin
          cnt <= '0;
          st  <= XB_STRB;
        end
        XB_STRB: begin
          if (cnt == ws_q) begin
            if (!we_q) rdata_q <= bus_in;
            st <= XB_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        XB_DONE: st <= XB_IDLE;
        default: st <= XB_IDLE;
      endcase
    end
  end

  always_comb begin
    ale      = 1'b0;
    wr_n     = 1'b1;
    rd_n     = 1'b1;
    ad_drive = 1'b0;
    ad_val   = addr_q[DATA_W-1:0];
    case (st)
      XB_ALE, XB_HOLD: begin
        ale      = (st == XB_ALE);
        ad_drive = 1'b1;
      end
      XB_STRB: begin
        wr_n     = !we_q;
        rd_n     = we_q;
        ad_drive = we_q;
        ad_val   = wdata_q;
      end
      XB_DONE: begin
        ad_drive = we_q;
        ad_val   = wdata_q;
      end
      default: ;
    endcase
  end

  assign hi_val    = addr_q[ADDR_W-1:DATA_W];
  assign req_ready = (st == XB_DONE);
  assign rsp_rdata = rdata_q;

  logic                 strb_any;
  logic [XB_WS_W:0]     strb_run;
  assign strb_any = !wr_n || !rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        strb_run <= '0;
    else if (strb_any) strb_run <= strb_run + 1'b1;
    else               strb_run <= '0;
  end

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n)); // R4
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_any) |-> (strb_run == ({1'b0, ws_q} + 1'b1))); // R5
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R10
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != XB_IDLE && st != XB_ALE) |-> $stable(hi_val)); // R13
endmodule

// File: rtl/xbus_pad_mux.sv
module xbus_pad_mux #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              keep_en,
  input  logic              ale,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ad_drive,
  input  logic [DATA_W-1:0] ad_val,
  input  logic [HI_W-1:0]   hi_val,
  input  logic [DATA_W-1:0] gpio_ad_out,
  input  logic [DATA_W-1:0] gpio_ad_dir,
  input  logic [HI_W-1:0]   gpio_hi_out,
  input  logic [HI_W-1:0]   gpio_hi_dir,
  input  logic [2:0]        gpio_ctl_out,
  input  logic [2:0]        gpio_ctl_dir,
  input  logic [DATA_W-1:0] pad_ad_i,
  output logic [DATA_W-1:0] pad_ad_o,
  output logic [DATA_W-1:0] pad_ad_oe,
  output logic [DATA_W-1:0] pad_ad_hold_en,
  output logic [DATA_W-1:0] pad_ad_hold_val,
  output logic [HI_W-1:0]   pad_hi_o,
  output logic [HI_W-1:0]   pad_hi_oe,
  output logic [2:0]        pad_ctl_o,
  output logic [2:0]        pad_ctl_oe
);
  always_comb begin
    if (en) begin
      pad_ad_o   = ad_val;
      pad_ad_oe  = {DATA_W{ad_drive}};
      pad_hi_o   = hi_val;
      pad_hi_oe  = '1;
      pad_ctl_o  = {rd_n, wr_n, ale};
      pad_ctl_oe = 3'b111;
    end else begin
      pad_ad_o   = gpio_ad_out;
      pad_ad_oe  = gpio_ad_dir;
      pad_hi_o   = gpio_hi_out;
      pad_hi_oe  = gpio_hi_dir;
      pad_ctl_o  = gpio_ctl_out;
      pad_ctl_oe = gpio_ctl_dir;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_keep
    logic held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held <= 1'b0;
      else if (keep_en) held <= pad_ad_oe[b] ? pad_ad_o[b] : pad_ad_i[b];
    end
    assign pad_ad_hold_en[b]  = keep_en && !pad_ad_oe[b];
    assign pad_ad_hold_val[b] = held;
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rd_n) |-> (pad_ad_oe == '0)); // R8
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int STEP_LOG2 = 13,
  localparam int HI_W     = ADDR_W - DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [XB_CFG_W-1:0] ctl_wdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [DATA_W-1:0]   gpio_ad_out,
  input  logic [DATA_W-1:0]   gpio_ad_dir,
  input  logic [HI_W-1:0]     gpio_hi_out,
  input  logic [HI_W-1:0]     gpio_hi_dir,
  input  logic [2:0]          gpio_ctl_out,
  input  logic [2:0]          gpio_ctl_dir,
  input  logic [DATA_W-1:0]   pad_ad_i,
  output logic [DATA_W-1:0]   pad_ad_o,
  output logic [DATA_W-1:0]   pad_ad_oe,
  output logic [DATA_W-1:0]   pad_ad_hold_en,
  output logic [DATA_W-1:0]   pad_ad_hold_val,
  output logic [HI_W-1:0]     pad_hi_o,
  output logic [HI_W-1:0]     pad_hi_oe,
  output logic [2:0]          pad_ctl_o,
  output logic [2:0]          pad_ctl_oe
);
  xb_cfg_t            cfg;
  logic [XB_WS_W-1:0] ws_sel;
  logic               ale, wr_n, rd_n, ad_drive;
  logic [DATA_W-1:0]  ad_val;
  logic [HI_W-1:0]    hi_val;

  xbus_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .cfg   (cfg)
  );

  xbus_sector_sel #(.ADDR_W(ADDR_W), .STEP_LOG2(STEP_LOG2)) u_sel (
    .addr  (req_addr),
    .lim   (cfg.lim),
    .ws_lo (cfg.ws_lo),
    .ws_up (cfg.ws_up),
    .ws    (ws_sel)
  );

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ws_sel    (ws_sel),
    .bus_in    (pad_ad_i),
    .req_ready (req_ready),
    .rsp_rdata (rsp_rdata),
    .ale       (ale),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .ad_drive  (ad_drive),
    .ad_val    (ad_val),
    .hi_val    (hi_val)
  );

  xbus_pad_mux #(.DATA_W(DATA_W), .HI_W(HI_W)) u_pad (
    .clk             (clk),
    .rst_n           (rst_n),
    .en              (cfg.en),
    .keep_en         (cfg.keep),
    .ale             (ale),
    .wr_n            (wr_n),
    .rd_n            (rd_n),
    .ad_drive        (ad_drive),
    .ad_val          (ad_val),
    .hi_val          (hi_val),
    .gpio_ad_out     (gpio_ad_out),
    .gpio_ad_dir     (gpio_ad_dir),
    .gpio_hi_out     (gpio_hi_out),
    .gpio_hi_dir     (gpio_hi_dir),
    .gpio_ctl_out    (gpio_ctl_out),
    .gpio_ctl_dir    (gpio_ctl_dir),
    .pad_ad_i        (pad_ad_i),
    .pad_ad_o        (pad_ad_o),
    .pad_ad_oe       (pad_ad_oe),
    .pad_ad_hold_en  (pad_ad_hold_en),
    .pad_ad_hold_val (pad_ad_hold_val),
    .pad_hi_o        (pad_hi_o),
    .pad_hi_oe       (pad_hi_oe),
    .pad_ctl_o       (pad_ctl_o),
    .pad_ctl_oe      (pad_ctl_oe)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !req_ready); // R10
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [8:0] ctl_wdata = '0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready;
  logic [7:0] rsp_rdata;
  logic [7:0] gpio_ad_out = '0, gpio_ad_dir = '0, gpio_hi_out = '0, gpio_hi_dir = '0;
  logic [2:0] gpio_ctl_out = '0, gpio_ctl_dir = '0;
  logic [7:0] bus;
  logic [7:0] pad_ad_o, pad_ad_oe, pad_ad_hold_en, pad_ad_hold_val, pad_hi_o, pad_hi_oe;
  logic [2:0] pad_ctl_o, pad_ctl_oe;

  int n_chk = 0, n_fail = 0;
  bit ctl_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl i_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .gpio_ad_out(gpio_ad_out), .gpio_ad_dir(gpio_ad_dir),
    .gpio_hi_out(gpio_hi_out), .gpio_hi_dir(gpio_hi_dir),
    .gpio_ctl_out(gpio_ctl_out), .gpio_ctl_dir(gpio_ctl_dir),
    .pad_ad_i(bus), .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe),
    .pad_ad_hold_en(pad_ad_hold_en), .pad_ad_hold_val(pad_ad_hold_val),
    .pad_hi_o(pad_hi_o), .pad_hi_oe(pad_hi_oe),
    .pad_ctl_o(pad_ctl_o), .pad_ctl_oe(pad_ctl_oe)
  );

  // external SRAM behind an address latch
  logic [7:0] mem [256];
  logic [7:0] latch_lo = '0;
  logic [7:0] sram_val;
  logic       sram_drv;
  always_comb begin
    sram_val = mem[latch_lo ^ pad_hi_o];
    sram_drv = ctl_on && pad_ctl_oe[2] && !pad_ctl_o[2];
    for (int b = 0; b < 8; b++)
      bus[b] = pad_ad_oe[b] ? pad_ad_o[b] :
               sram_drv ? sram_val[b] :
               pad_ad_hold_en[b] ? pad_ad_hold_val[b] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { bit we; logic [15:0] addr; logic [7:0] data; int len; } exp_t;
  exp_t q[$];

  // monitor
  int ale_run = 0, strb_run = 0;
  bit last_we = 1'b0;
  logic [7:0] last_bus = '0, last_hi = '0, hold_bus = '0;
  always @(negedge clk) begin
    if (ctl_on) begin
      if (pad_ctl_o[0]) begin
        latch_lo = bus;
        ale_run++;
      end else if (ale_run != 0) begin
        chk(ale_run == 1, "R4 ale length", ale_run, 1);
        chk(bus == latch_lo, "R4 addr held after ALE", bus, latch_lo);
        ale_run = 0;
      end
      if (!pad_ctl_o[1] || !pad_ctl_o[2]) begin
        chk(pad_ctl_o[1] || pad_ctl_o[2], "R4 strobes exclusive", pad_ctl_o, 3'b110);
        strb_run++;
        last_we  = !pad_ctl_o[1];
        last_bus = bus;
        last_hi  = pad_hi_o;
        if (last_we) mem[latch_lo ^ pad_hi_o] = bus;
      end else if (strb_run != 0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4 unexpected access", 0, 1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(strb_run == e.len, "R5 R6 R7 strobe length", strb_run, e.len);
          chk(last_we == e.we, "R4 strobe kind", last_we, e.we);
          chk({last_hi, latch_lo} == e.addr, "R13 address", {last_hi, latch_lo}, e.addr);
          if (e.we) begin
            chk(last_bus == e.data, "R9 write data in strobe", last_bus, e.data);
            chk(bus == e.data, "R9 write data hold", bus, e.data);
          end
        end
        strb_run = 0;
      end
    end
  end

  function automatic int exp_len(logic [8:0] c, logic [15:0] a);
    logic [2:0] lim;
    logic [1:0] ws;
    lim = c[3:1];
    if (lim == 0) ws = c[7:6];
    else if (int'(a) < int'(lim) * 32'h2000) ws = c[5:4];
    else ws = c[7:6];
    return int'(ws) + 1;
  endfunction

  logic [8:0] cur_ctl = '0;

  task automatic set_ctl(input bit en, input logic [2:0] lim, input logic [1:0] lo,
                         input logic [1:0] up, input bit keep);
    @(negedge clk);
    ctl_wdata = {keep, up, lo, lim, en};
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    cur_ctl = ctl_wdata;
    ctl_on = en;
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d,
                        input logic [7:0] exp_rd);
    exp_t e;
    int len, n;
    len = exp_len(cur_ctl, a);
    e.we = we; e.addr = a; e.data = d; e.len = len;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ready && n < 40);
    chk(n == 3 + len, "R10 ready timing", n, 3 + len);
    if (!we) chk(rsp_rdata == exp_rd, "R8 read data", rsp_rdata, exp_rd);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready one cycle", req_ready, 0);
  endtask

  task automatic run();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    gpio_ad_out = 8'h81; gpio_ad_dir = 8'h3C;
    gpio_hi_out = 8'h42; gpio_hi_dir = 8'hF0;
    gpio_ctl_out = 3'b101; gpio_ctl_dir = 3'b011;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state and release
    chk(!req_ready, "R1 ready low", req_ready, 0);
    chk(pad_ad_hold_en == 0, "R1 keeper off", pad_ad_hold_en, 0);
    chk(pad_ad_o == 8'h81 && pad_ad_oe == 8'h3C, "R3 shared pins to port", {pad_ad_o, pad_ad_oe}, 16'h813C);
    chk(pad_hi_o == 8'h42 && pad_hi_oe == 8'hF0, "R3 high pins to port", {pad_hi_o, pad_hi_oe}, 16'h42F0);
    chk(pad_ctl_o == 3'b101 && pad_ctl_oe == 3'b011, "R3 strobe pins to port", {pad_ctl_o, pad_ctl_oe}, 6'b101011);
    // disabled request ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2010; req_wdata = 8'hEE;
    begin
      int seen;
      seen = 0;
      repeat (10) begin
        @(negedge clk);
        if (req_ready || pad_ctl_o != 3'b101) seen++;
      end
      chk(seen == 0, "R10 no accept while disabled", seen, 0);
    end
    req_valid = 1'b0;
    // enable, one sector
    gpio_ad_dir = 8'h00; gpio_hi_dir = 8'h00; gpio_ctl_dir = 3'b000;
    set_ctl(1'b1, 3'd0, 2'd3, 2'd1, 1'b0);
    chk(pad_hi_oe == 8'hFF && pad_ctl_oe == 3'b111, "R2 pins owned", {pad_hi_oe, pad_ctl_oe}, 11'h7FF);
    chk(pad_ctl_o == 3'b110 && pad_ad_oe == 8'h00, "R2 idle levels", {pad_ctl_o, pad_ad_oe}, 11'h600);
    access(1'b1, 16'h2010, 8'h3C, 8'h00); // R6
    access(1'b0, 16'h2010, 8'h00, 8'h3C); // R6 R8
    access(1'b1, 16'h1234, 8'h96, 8'h00); // R6
    // split code 2
    set_ctl(1'b1, 3'd2, 2'd2, 2'd0, 1'b0);
    access(1'b1, 16'h3FFF, 8'h11, 8'h00); // R7 lower
    access(1'b1, 16'h4000, 8'h22, 8'h00); // R7 upper
    access(1'b0, 16'h3FFF, 8'h00, 8'h11);
    access(1'b0, 16'h4000, 8'h00, 8'h22);
    // split code 7
    set_ctl(1'b1, 3'd7, 2'd3, 2'd2, 1'b0);
    access(1'b1, 16'hDFFF, 8'h77, 8'h00); // R7
    access(1'b1, 16'hE000, 8'h88, 8'h00); // R7
    access(1'b0, 16'hDFFF, 8'h00, 8'h77);
    access(1'b0, 16'hE000, 8'h00, 8'h88);
    chk(pad_ad_hold_en == 0, "R11 keeper off no hold", pad_ad_hold_en, 0);
    // keeper on while enabled
    set_ctl(1'b1, 3'd7, 2'd0, 2'd0, 1'b1);
    access(1'b1, 16'h1234, 8'h5A, 8'h00);
    repeat (2) @(negedge clk);
    chk(pad_ad_hold_en == 8'hFF, "R11 keeper lines", pad_ad_hold_en, 8'hFF);
    chk(bus == 8'h5A, "R11 bus held after write", bus, 8'h5A);
    access(1'b0, 16'hE000, 8'h00, 8'h88);
    repeat (2) @(negedge clk);
    chk(bus == 8'h88, "R11 bus held after read", bus, 8'h88);
    // keeper with interface disabled
    gpio_ad_out = 8'hC3; gpio_ad_dir = 8'hFF;
    set_ctl(1'b0, 3'd0, 2'd0, 2'd0, 1'b1);
    repeat (2) @(negedge clk);
    chk(pad_ad_o == 8'hC3 && pad_ad_oe == 8'hFF, "R3 port drives", {pad_ad_o, pad_ad_oe}, 16'hC3FF);
    gpio_ad_dir = 8'h00;
    repeat (3) @(negedge clk);
    chk(pad_ad_hold_en == 8'hFF, "R12 keeper active while disabled", pad_ad_hold_en, 8'hFF);
    chk(bus == 8'hC3, "R12 bus held while disabled", bus, 8'hC3);
    set_ctl(1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
    chk(pad_ad_hold_en == 8'h00, "R11 keeper released", pad_ad_hold_en, 0);
    chk(q.size() == 0, "R4 all accesses seen", q.size(), 0);
  endtask

  initial begin
    fork
      begin run(); done = 1'b1; end
      begin
        repeat (100000) @(posedge clk);
        if (!done) chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule